// File: doc/BRIEF.md
# BCD Up/Down Decade Counter

A single decimal digit counter that steps up or down by one on each rising clock edge while its active-low enable is held LOW. A parallel load input, when HIGH, makes the count follow a 4-bit data word at once, with no clock edge needed. An active-low master reset clears the count immediately and overrides everything else.

An active-low terminal-count output flags the last digit in the current direction: 9 when counting up and 0 when counting down. It is gated by the enable. To build a multi-digit counter, put all digits on one clock and drive each digit's enable from the terminal count of the digit below it. Codes 10 to 15 can only enter through the load path. The counter leaves them on the next counting edge.

Top module: `bcd_updown_decade`

## Requirements
- R1: While rst_ni is LOW, cnt_o is 0000 at once, whatever clk_i, load_i, data_i, ce_n_i and up_i are doing.
- R2: While load_i is HIGH and rst_ni is HIGH, cnt_o follows data_i without any clock edge. Rising clock edges do not change it. If rst_ni rises while load_i is HIGH, cnt_o takes data_i.
- R3: With load_i LOW and ce_n_i HIGH, cnt_o holds its value across rising clock edges.
- R4: With load_i LOW, ce_n_i LOW and up_i HIGH, each rising clock edge adds one to cnt_o, and 9 wraps to 0.
- R5: With load_i LOW, ce_n_i LOW and up_i LOW, each rising clock edge subtracts one from cnt_o, and 0 wraps to 9.
- R6: From a loaded code of 10 to 15, the next counting edge gives 0 when up_i is HIGH and 9 when up_i is LOW.
- R7: With up_i HIGH, tc_n_o is LOW exactly when ce_n_i is LOW and cnt_o bits 0 and 3 are both 1. For example, 9 and 11 give LOW and 10 gives HIGH.
- R8: With up_i LOW, tc_n_o is LOW exactly when ce_n_i is LOW and cnt_o is 0000. In every other case tc_n_o is HIGH.
- R9: tc_n_o is combinational from ce_n_i, up_i and cnt_o. A change on ce_n_i or up_i reaches it without a clock edge.
- R10: Two digits on a shared clock, with the upper enable tied to the lower tc_n_o, count 00 to 99 and wrap to 00 going up. Going down they step from 00 to 99 and back to 00 with the correct borrow.
- R11: After load_i falls, counting resumes from the loaded value on the next enabled rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock, rising edge |
| rst_ni | input | 1 | Asynchronous master reset, active LOW |
| load_i | input | 1 | Asynchronous parallel load, active HIGH |
| data_i | input | 4 | Parallel load value |
| ce_n_i | input | 1 | Count enable, active LOW |
| up_i | input | 1 | Direction: 1 counts up, 0 counts down |
| cnt_o | output | 4 | Current BCD digit |
| tc_n_o | output | 1 | Terminal count, active LOW |

## Verification
The bench loads and resets in the middle of a clock period and samples before any edge. A design that synchronised either control to the clock would still show the old digit there. It drives codes 10 to 15 in both directions, which exposes a next-state function that only handles the legal range, for example one that steps 12 to 13 or 15 to 14. It toggles the enable between edges to catch a registered terminal count, and it probes the up decode at 11 and 10 to catch a full compare against 9. A two-digit chain covering the whole range in both directions shows any carry or borrow that fires a cycle early or late.

// File: rtl/bcd_pkg.sv
`timescale 1ns/1ps
package bcd_pkg;
  localparam int unsigned DIGIT_W = 4;
  localparam logic [DIGIT_W-1:0] DIGIT_MAX = 4'd9;
  typedef logic [DIGIT_W-1:0] digit_t;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/bcd_step.sv
`timescale 1ns/1ps
module bcd_step
  import bcd_pkg::*;
(
  input  digit_t cnt_i,
  input  logic   up_i,
  output digit_t nxt_o
);
  logic over_top;
  logic at_floor;

  assign over_top = (cnt_i >= DIGIT_MAX);
  assign at_floor = (cnt_i == '0) || (cnt_i > DIGIT_MAX);

  always_comb begin
    if (dir_e'(up_i) == DIR_UP) nxt_o = over_top ? '0 : cnt_i + digit_t'(1);
    else                        nxt_o = at_floor ? DIGIT_MAX : cnt_i - digit_t'(1);
  end
endmodule

// File: rtl/bcd_tc_dec.sv
`timescale 1ns/1ps
module bcd_tc_dec
  import bcd_pkg::*;
(
  input  digit_t cnt_i,
  input  logic   up_i,
  input  logic   ce_n_i,
  output logic   tc_n_o
);
  logic hit_up, hit_dn;

  // up decode looks at the two bits that are set in 9 only
  assign hit_up = cnt_i[0] & cnt_i[DIGIT_W-1];
  assign hit_dn = (cnt_i == '0);
  assign tc_n_o = ~(~ce_n_i & (up_i ? hit_up : hit_dn));
endmodule

// File: rtl/bcd_bit_cell.sv
`timescale 1ns/1ps
module bcd_bit_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ld_set_i,
  input  logic ld_clr_i,
  input  logic d_i,
  output logic q_o
);
  // reset, then load set/clear, then clocked data
  always_ff @(posedge clk_i or negedge rst_ni or posedge ld_set_i or posedge ld_clr_i) begin
    if (!rst_ni)       q_o <= 1'b0;
    else if (ld_set_i) q_o <= 1'b1;
    else if (ld_clr_i) q_o <= 1'b0;
    else               q_o <= d_i;
  end
endmodule

// File: rtl/bcd_updown_decade.sv
`timescale 1ns/1ps
module bcd_updown_decade
  import bcd_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [DIGIT_W-1:0] data_i,
  input  logic               ce_n_i,
  input  logic               up_i,
  output logic [DIGIT_W-1:0] cnt_o,
  output logic               tc_n_o
);
  digit_t cnt_q, cnt_step, cnt_d;
  digit_t ld_set, ld_clr;

  bcd_step u_step (.cnt_i(cnt_q), .up_i(up_i), .nxt_o(cnt_step));

  assign cnt_d = ce_n_i ? cnt_q : cnt_step;

  for (genvar b = 0; b < DIGIT_W; b++) begin : g_bit
    // rst_ni in the set term lets a held load land when reset releases
    assign ld_set[b] = rst_ni & load_i & data_i[b];
    assign ld_clr[b] = load_i & ~data_i[b];
    bcd_bit_cell u_cell (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ld_set_i(ld_set[b]),
      .ld_clr_i(ld_clr[b]),
      .d_i     (cnt_d[b]),
      .q_o     (cnt_q[b])
    );
  end

  bcd_tc_dec u_tc (.cnt_i(cnt_q), .up_i(up_i), .ce_n_i(ce_n_i), .tc_n_o(tc_n_o));

  assign cnt_o = cnt_q;

  // marks a cycle in which reset or load acted asynchronously
  logic async_hit_q;
  always_ff @(posedge clk_i or posedge load_i or negedge rst_ni) begin
    if (!rst_ni)     async_hit_q <= 1'b1;
    else if (load_i) async_hit_q <= 1'b1;
    else             async_hit_q <= 1'b0;
  end

  // R1
  always @(posedge clk_i) if (!rst_ni) rst_clear_chk: assert (cnt_o == '0);

  // R2
  load_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> cnt_o == data_i);

  // R3
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && ce_n_i) |=> (async_hit_q || cnt_o == $past(cnt_o)));

  // R4
  up_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !ce_n_i && up_i && cnt_o < DIGIT_MAX)
      |=> (async_hit_q || cnt_o == $past(cnt_o) + digit_t'(1)));

  // R4 R6
  up_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !ce_n_i && up_i && cnt_o >= DIGIT_MAX) |=> (async_hit_q || cnt_o == '0));

  // R5 R6
  dn_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !ce_n_i && !up_i && (cnt_o == '0 || cnt_o > DIGIT_MAX))
      |=> (async_hit_q || cnt_o == DIGIT_MAX));

  // R7 R8
  tc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_i |-> tc_n_o);

  // R7
  tc_nine_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_n_i && up_i && cnt_o == DIGIT_MAX) |-> !tc_n_o);
endmodule

// File: tb/bcd_updown_decade_test.sv
`timescale 1ns/1ps
module bcd_updown_decade_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load = 1'b0;
  logic [3:0] data = 4'd0;
  logic       ce_n = 1'b1;
  logic       up = 1'b1;
  logic [3:0] cnt, cnt_hi;
  logic       tc_n, tc_n_hi;
  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  bcd_updown_decade uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .data_i(data),
    .ce_n_i(ce_n), .up_i(up), .cnt_o(cnt), .tc_n_o(tc_n));

  bcd_updown_decade uut_hi (
    .clk_i(clk), .rst_ni(rst_n), .load_i(1'b0), .data_i(4'd0),
    .ce_n_i(tc_n), .up_i(up), .cnt_o(cnt_hi), .tc_n_o(tc_n_hi));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one rising edge, return just after the following falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  function automatic int ref_next(input int v, input bit dir_up);
    if (dir_up) return (v >= 9) ? 0 : v + 1;
    return (v == 0 || v > 9) ? 9 : v - 1;
  endfunction

  task automatic load_val(input int v);
    load = 1'b1; data = 4'(v); #2; load = 1'b0; #1;
  endtask

  task automatic t_reset();
    chk("R1 count in reset", cnt, 0);
    rst_n = 1'b1; step();
    chk("R1 count after release", cnt, 0);
    chk("R8 tc idle high", tc_n, 1);
  endtask

  task automatic t_hold();
    load_val(6); ce_n = 1'b1; up = 1'b1;
    for (int i = 0; i < 3; i++) step();
    chk("R3 hold while disabled", cnt, 6);
  endtask

  task automatic t_up();
    int exp = 7;
    load_val(7); ce_n = 1'b0; up = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(); exp = ref_next(exp, 1'b1);
      chk("R4 up step", cnt, exp);
    end
    ce_n = 1'b1;
  endtask

  task automatic t_down();
    int exp = 2;
    load_val(2); ce_n = 1'b0; up = 1'b0;
    for (int i = 0; i < 5; i++) begin
      step(); exp = ref_next(exp, 1'b0);
      chk("R5 down step", cnt, exp);
    end
    ce_n = 1'b1;
  endtask

  task automatic t_illegal();
    for (int v = 10; v < 16; v++) begin
      load_val(v); ce_n = 1'b0; up = 1'b1; step();
      chk("R6 illegal up", cnt, 0);
      ce_n = 1'b1;
      load_val(v); ce_n = 1'b0; up = 1'b0; step();
      chk("R6 illegal down", cnt, 9);
      ce_n = 1'b1;
    end
  endtask

  task automatic t_load_async();
    ce_n = 1'b0; up = 1'b1;
    load = 1'b1; data = 4'd7; #2;
    chk("R2 load without edge", cnt, 7);
    data = 4'd3; #2;
    chk("R2 load follows data", cnt, 3);
    step();
    chk("R2 clock ignored in load", cnt, 3);
    load = 1'b0; step();
    chk("R11 count after load", cnt, 4);
    ce_n = 1'b1;
  endtask

  task automatic t_reset_override();
    load = 1'b1; data = 4'd5; ce_n = 1'b0; #2;
    rst_n = 1'b0; #2;
    chk("R1 reset beats load", cnt, 0);
    step();
    chk("R1 reset beats clock", cnt, 0);
    rst_n = 1'b1; #2;
    chk("R2 load after reset release", cnt, 5);
    load = 1'b0; ce_n = 1'b1; #1;
  endtask

  task automatic t_tc();
    load_val(9); up = 1'b1; ce_n = 1'b1; #1;
    chk("R7 tc gated by enable", tc_n, 1);
    ce_n = 1'b0; #1;
    chk("R9 tc follows enable", tc_n, 0);
    ce_n = 1'b1; load_val(11); ce_n = 1'b0; #1;
    chk("R7 tc on 11", tc_n, 0);
    ce_n = 1'b1; load_val(10); ce_n = 1'b0; #1;
    chk("R7 tc off on 10", tc_n, 1);
    ce_n = 1'b1; load_val(0); ce_n = 1'b0; #1;
    chk("R7 tc off at 0 up", tc_n, 1);
    up = 1'b0; #1;
    chk("R8 tc down at 0", tc_n, 0);
    chk("R9 tc follows direction", tc_n, 0);
    ce_n = 1'b1; load_val(9); ce_n = 1'b0; #1;
    chk("R8 tc off at 9 down", tc_n, 1);
    ce_n = 1'b1; #1;
  endtask

  task automatic t_cascade();
    int exp = 0;
    rst_n = 1'b0; #2; rst_n = 1'b1; up = 1'b1; ce_n = 1'b0;
    for (int i = 0; i < 100; i++) begin
      step(); exp = (exp + 1) % 100;
      chk("R10 chain up", cnt_hi * 10 + cnt, exp);
    end
    chk("R10 chain wrap up", cnt_hi * 10 + cnt, 0);
    up = 1'b0;
    for (int i = 0; i < 100; i++) begin
      step(); exp = (exp + 99) % 100;
      chk("R10 chain down", cnt_hi * 10 + cnt, exp);
    end
    ce_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    fails++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk); #1;
    t_reset();
    t_hold();
    t_up();
    t_down();
    t_illegal();
    t_load_async();
    t_reset_override();
    t_tc();
    t_cascade();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule